// File: doc/BRIEF.md
# Snapshot Event Counter Peripheral

This block is a small register-mapped peripheral for a processor with an 8-bit data bus. It keeps four free-running 64-bit tallies driven by a step interface from the core: total clock cycles, retired instructions, interrupt entries and non-maskable interrupt entries. The core reports each completed step with its kind and the number of cycles it took.

Software takes a coherent picture of the machine by writing any value to a single capture address. That one write copies the four tallies and two 64-bit time values, taken from an external time input, into six shadow registers in the same clock. A one-byte selector then chooses which shadow is visible in an eight-byte read window. Software can read the 64-bit value one byte at a time and the bytes always belong to the same capture.

Read data is registered. It shows the addressed byte one clock after the address is presented.

Top module: `snap_counter_periph`

## Requirements
- R1: The cycle tally adds `step_cycles` on every clock with `step_valid` high, whatever the step kind, and carries across byte boundaries.
- R2: `step_kind` encodes 0 = instruction, 1 = interrupt entry, 2 = non-maskable interrupt entry, 3 = other. The instruction, interrupt and non-maskable tallies each add one only for their own kind, so interrupt entries never count as instructions. Kind 3 advances only the cycle tally.
- R3: A write of any data to offset 0x0 copies all six sources into their shadows in one clock. Without such a write the shadows hold their value while the tallies move on.
- R4: When a capture write and a step fall in the same clock, the shadows receive the tally values from before that step.
- R5: Shadow 4 captures `time_ns`. Shadow 5 captures `time_sec` in its upper 32 bits and `time_subns` in its lower 32 bits.
- R6: If `time_valid` is low at the capture clock, shadows 4 and 5 are both loaded with all ones.
- R7: Offset 0x1 is an 8-bit read/write selector. Codes 0..5 choose cycles, instructions, interrupts, non-maskable interrupts, nanosecond time and split time.
- R8: Offsets 0x8..0xF form the read window. Offset 0x8 gives bits 7:0 and offset 0xF gives bits 63:56 of the selected shadow. `rd_data` shows the byte for the address presented in the previous clock.
- R9: A selector code above 5 makes every window byte read as zero.
- R10: Reads of offset 0x0 and of offsets 0x2..0x7 return zero. Writes to offsets 0x2..0x7 and to the window have no effect.
- R11: Synchronous active-high reset clears all tallies, all shadows, the selector and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous clock's address |
| step_valid | input | 1 | Core completed one step this clock |
| step_kind | input | 2 | Step kind: 0 instruction, 1 interrupt, 2 non-maskable, 3 other |
| step_cycles | input | 8 | Cycles the step consumed |
| time_valid | input | 1 | Time inputs are trustworthy |
| time_ns | input | 64 | Nanosecond time count |
| time_sec | input | 32 | Whole seconds |
| time_subns | input | 32 | Nanoseconds within the current second |

## Verification
The bench captures, keeps stepping the core, and then reads back. A design whose shadows follow the live tallies would return the newer count. A step is issued in the same clock as a capture. A design that forwarded the incremented value would read one instruction and ten cycles too many. Every window byte of a known time word is read, so swapped byte order or a wrong split between seconds and nanoseconds shows up. The bench also checks out-of-range selector codes, the invalid-time case, a carry out of the low byte, and writes to the window and to unused offsets. A design that leaked data there or let those writes land would return nonzero or altered bytes.

// File: rtl/snapc_pkg.sv
package snapc_pkg;
  localparam int NUM_LIVE = 4;
  localparam int NUM_SRC  = 6;

  localparam int LIVE_CYC  = 0;
  localparam int LIVE_INSN = 1;
  localparam int LIVE_IRQ  = 2;
  localparam int LIVE_NMI  = 3;
  localparam int SRC_TNS   = 4;
  localparam int SRC_TSPL  = 5;

  localparam logic [7:0] OFS_CAPTURE = 8'h00;
  localparam logic [7:0] OFS_SELECT  = 8'h01;

  typedef enum logic [1:0] {
    STEP_INSN  = 2'd0,
    STEP_IRQ   = 2'd1,
    STEP_NMI   = 2'd2,
    STEP_OTHER = 2'd3
  } step_kind_e;
endpackage

// File: rtl/snapc_live_ctr.sv
module snapc_live_ctr #(
  parameter int W     = 64,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_val,
  output logic [W-1:0]     count
);
  logic [W-1:0] inc_ext;
  assign inc_ext = {{(W-INC_W){1'b0}}, inc_val};

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (inc_en) count <= count + inc_ext;
  end
endmodule

// File: rtl/snapc_shadow_bank.sv
module snapc_shadow_bank #(
  parameter int W   = 64,
  parameter int NUM = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  logic [NUM-1:0][W-1:0]   src,
  output logic [NUM-1:0][W-1:0]   shadow
);
  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)          shadow[g] <= '0;
      else if (capture) shadow[g] <= src[g];
    end
  end
endmodule

// File: rtl/snapc_window_mux.sv
module snapc_window_mux #(
  parameter int W   = 64,
  parameter int NUM = 6
) (
  input  logic [7:0]                   sel,
  input  logic [$clog2(W/8)-1:0]       byte_idx,
  input  logic [NUM-1:0][W-1:0]        shadow,
  output logic [7:0]                   win_byte
);
  logic [W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM; i++) begin
      if (sel == 8'(i)) word = shadow[i];
    end
    win_byte = word[{byte_idx, 3'b000} +: 8];
  end
endmodule

// File: rtl/snap_counter_periph.sv
module snap_counter_periph
  import snapc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 4,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  input  logic              step_valid,
  input  logic [1:0]        step_kind,
  input  logic [CYC_W-1:0]  step_cycles,
  input  logic              time_valid,
  input  logic [CNT_W-1:0]  time_ns,
  input  logic [CNT_W/2-1:0] time_sec,
  input  logic [CNT_W/2-1:0] time_subns
);
  localparam int WIN_BYTES = CNT_W / 8;
  localparam int BIDX_W    = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(2 * WIN_BYTES - 1);

  logic [NUM_LIVE-1:0][CNT_W-1:0] live_q;
  logic [NUM_LIVE-1:0]            inc_en;
  logic [NUM_LIVE-1:0][CYC_W-1:0] inc_val;
  logic [NUM_SRC-1:0][CNT_W-1:0]  src;
  logic [NUM_SRC-1:0][CNT_W-1:0]  shadow_q;
  logic [7:0]                     sel_q;
  logic [7:0]                     win_byte;
  logic [7:0]                     rd_next;
  logic                           do_capture;
  logic                           do_select;
  logic                           in_window;

  always_comb begin
    inc_en  = '0;
    inc_val = '0;
    inc_en[LIVE_CYC]   = step_valid;
    inc_val[LIVE_CYC]  = step_cycles;
    inc_en[LIVE_INSN]  = step_valid && (step_kind == STEP_INSN);
    inc_val[LIVE_INSN] = CYC_W'(1);
    inc_en[LIVE_IRQ]   = step_valid && (step_kind == STEP_IRQ);
    inc_val[LIVE_IRQ]  = CYC_W'(1);
    inc_en[LIVE_NMI]   = step_valid && (step_kind == STEP_NMI);
    inc_val[LIVE_NMI]  = CYC_W'(1);
  end

  for (genvar g = 0; g < NUM_LIVE; g++) begin : g_live
    snapc_live_ctr #(.W(CNT_W), .INC_W(CYC_W)) ctr_i (
      .clk     (clk),
      .rst     (rst),
      .inc_en  (inc_en[g]),
      .inc_val (inc_val[g]),
      .count   (live_q[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_LIVE; i++) src[i] = live_q[i];
    src[SRC_TNS]  = time_valid ? time_ns : '1;
    src[SRC_TSPL] = time_valid ? {time_sec, time_subns} : '1;
  end

  assign do_capture = bus_wr && (bus_addr == ADDR_W'(OFS_CAPTURE));
  assign do_select  = bus_wr && (bus_addr == ADDR_W'(OFS_SELECT));
  assign in_window  = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);

  snapc_shadow_bank #(.W(CNT_W), .NUM(NUM_SRC)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .capture (do_capture),
    .src     (src),
    .shadow  (shadow_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            sel_q <= '0;
    else if (do_select) sel_q <= bus_wdata;
  end

  snapc_window_mux #(.W(CNT_W), .NUM(NUM_SRC)) mux_i (
    .sel      (sel_q),
    .byte_idx (bus_addr[BIDX_W-1:0]),
    .shadow   (shadow_q),
    .win_byte (win_byte)
  );

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_SELECT)) rd_next = sel_q;
    else if (in_window)                  rd_next = win_byte;
    else                                 rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/snapc_checker.sv
module snapc_checker
  import snapc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          step_valid,
  input logic [1:0]                    step_kind,
  input logic                          time_valid,
  input logic [7:0]                    rd_data,
  input logic [NUM_LIVE-1:0][CNT_W-1:0] live_q,
  input logic [NUM_SRC-1:0][CNT_W-1:0]  shadow_q
);
  localparam int WIN_BYTES = CNT_W / 8;

  logic cap_w;
  logic quiet_addr;
  assign cap_w = bus_wr && (bus_addr == ADDR_W'(OFS_CAPTURE));
  assign quiet_addr = (bus_addr != ADDR_W'(OFS_SELECT)) &&
                      ((int'(bus_addr) < WIN_BYTES) || (int'(bus_addr) >= 2 * WIN_BYTES));

  p_cyc_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> $stable(live_q[LIVE_CYC]));

  p_insn_kind_r2: assert property (@(posedge clk) disable iff (rst)
    (!step_valid || step_kind != STEP_INSN) |=> $stable(live_q[LIVE_INSN]));

  p_irq_kind_r2: assert property (@(posedge clk) disable iff (rst)
    (!step_valid || step_kind != STEP_IRQ) |=> $stable(live_q[LIVE_IRQ]));

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_w |=> $stable(shadow_q));

  p_capture_pre_r4: assert property (@(posedge clk) disable iff (rst)
    cap_w |=> (shadow_q[LIVE_CYC] == $past(live_q[LIVE_CYC])) &&
              (shadow_q[LIVE_INSN] == $past(live_q[LIVE_INSN])));

  p_bad_time_r6: assert property (@(posedge clk) disable iff (rst)
    (cap_w && !time_valid) |=> (shadow_q[SRC_TNS] == '1) && (shadow_q[SRC_TSPL] == '1));

  p_quiet_read_r10: assert property (@(posedge clk) disable iff (rst)
    quiet_addr |=> rd_data == 8'h00);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h00) && (live_q == '0) && (shadow_q == '0));
endmodule

bind snap_counter_periph snapc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .step_valid (step_valid),
  .step_kind  (step_kind),
  .time_valid (time_valid),
  .rd_data    (rd_data),
  .live_q     (live_q),
  .shadow_q   (shadow_q)
);

// File: tb/snap_counter_periph_tb.sv
module snap_counter_periph_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        step_valid = 1'b0;
  logic [1:0]  step_kind = '0;
  logic [7:0]  step_cycles = '0;
  logic        time_valid = 1'b1;
  logic [63:0] time_ns = 64'h0123_4567_89AB_CDEF;
  logic [31:0] time_sec = 32'h6000_0001;
  logic [31:0] time_subns = 32'h1234_5678;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_counter_periph dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .step_valid(step_valid),
    .step_kind(step_kind), .step_cycles(step_cycles), .time_valid(time_valid),
    .time_ns(time_ns), .time_sec(time_sec), .time_subns(time_subns)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 40;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'h1, 8'h00, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'h1C, 4'd1},   // R1 cycles 28; R3 held despite later step
    '{1'b0, 4'h9, 8'h00, 8'h00, 4'd8},
    '{1'b1, 4'h1, 8'h01, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'h03, 4'd2},   // R2 three instructions
    '{1'b1, 4'h1, 8'h02, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'h01, 4'd2},   // R2 one IRQ
    '{1'b1, 4'h1, 8'h03, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'h01, 4'd2},   // R2 one NMI
    '{1'b1, 4'h1, 8'h04, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'hEF, 4'd8},   // R8 byte order, R5 ns
    '{1'b0, 4'h9, 8'h00, 8'hCD, 4'd8},
    '{1'b0, 4'hA, 8'h00, 8'hAB, 4'd8},
    '{1'b0, 4'hB, 8'h00, 8'h89, 4'd8},
    '{1'b0, 4'hC, 8'h00, 8'h67, 4'd8},
    '{1'b0, 4'hD, 8'h00, 8'h45, 4'd8},
    '{1'b0, 4'hE, 8'h00, 8'h23, 4'd8},
    '{1'b0, 4'hF, 8'h00, 8'h01, 4'd8},
    '{1'b1, 4'h1, 8'h05, 8'h00, 4'd7},
    '{1'b0, 4'h8, 8'h00, 8'h78, 4'd5},   // R5 split time
    '{1'b0, 4'hB, 8'h00, 8'h12, 4'd5},
    '{1'b0, 4'hC, 8'h00, 8'h01, 4'd5},
    '{1'b0, 4'hF, 8'h00, 8'h60, 4'd5},
    '{1'b0, 4'h1, 8'h00, 8'h05, 4'd7},   // R7 selector readback
    '{1'b1, 4'h1, 8'h06, 8'h00, 4'd9},
    '{1'b0, 4'h8, 8'h00, 8'h00, 4'd9},   // R9 code 6
    '{1'b1, 4'h1, 8'hFF, 8'h00, 4'd9},
    '{1'b0, 4'hF, 8'h00, 8'h00, 4'd9},   // R9 code 255
    '{1'b0, 4'h1, 8'h00, 8'hFF, 4'd7},
    '{1'b0, 4'h0, 8'h00, 8'h00, 4'd10},  // R10 write-only offset
    '{1'b0, 4'h2, 8'h00, 8'h00, 4'd10},
    '{1'b0, 4'h7, 8'h00, 8'h00, 4'd10},
    '{1'b1, 4'h3, 8'h55, 8'h00, 4'd10},
    '{1'b1, 4'h9, 8'hAA, 8'h00, 4'd10},
    '{1'b0, 4'h1, 8'h00, 8'hFF, 4'd10},  // R10 selector untouched
    '{1'b1, 4'h1, 8'h04, 8'h00, 4'd10},
    '{1'b0, 4'h9, 8'h00, 8'hCD, 4'd10},  // R10 window write ignored
    '{1'b1, 4'h1, 8'h00, 8'h00, 4'd3},
    '{1'b0, 4'h8, 8'h00, 8'h1C, 4'd3},   // R3 shadow held
    '{1'b0, 4'h9, 8'h00, 8'h00, 4'd3}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rd_data actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input int req);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    check(rd_data, exp, req);
  endtask

  task automatic do_step(input logic [1:0] k, input logic [7:0] c);
    step_valid = 1'b1; step_kind = k; step_cycles = c;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    bus_read(4'h1, 8'h00, 11);
    bus_read(4'h8, 8'h00, 11);

    do_step(2'd0, 8'd3);
    do_step(2'd0, 8'd5);
    do_step(2'd1, 8'd7);
    do_step(2'd2, 8'd7);
    do_step(2'd0, 8'd2);
    do_step(2'd3, 8'd4);
    bus_write(4'h0, 8'hA5);
    do_step(2'd0, 8'd9);   // live now 37 cycles, 4 insns

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else           bus_read(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
    end

    // R4: capture and step in the same clock keep the pre-step values
    bus_addr = 4'h0; bus_wdata = 8'h3C; bus_wr = 1'b1;
    step_valid = 1'b1; step_kind = 2'd0; step_cycles = 8'd10;
    @(negedge clk);
    bus_wr = 1'b0; step_valid = 1'b0;
    bus_write(4'h1, 8'h00);
    bus_read(4'h8, 8'h25, 4);
    bus_write(4'h1, 8'h01);
    bus_read(4'h8, 8'h04, 4);
    bus_write(4'h0, 8'h00);
    bus_read(4'h8, 8'h05, 4);
    bus_write(4'h1, 8'h00);
    bus_read(4'h8, 8'h2F, 4);

    // R1: carry out of the low byte (47 + 240 = 287)
    do_step(2'd3, 8'hF0);
    bus_write(4'h0, 8'h11);
    bus_read(4'h8, 8'h1F, 1);
    bus_read(4'h9, 8'h01, 1);

    // R6: invalid time loads all ones
    time_valid = 1'b0;
    bus_write(4'h0, 8'h22);
    time_valid = 1'b1;
    bus_write(4'h1, 8'h04);
    bus_read(4'hB, 8'hFF, 6);
    bus_read(4'h8, 8'hFF, 6);
    bus_write(4'h1, 8'h05);
    bus_read(4'hF, 8'hFF, 6);
    bus_read(4'h8, 8'hFF, 6);

    // R11: mid-run reset clears selector, shadows and tallies
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bus_read(4'h1, 8'h00, 11);
    bus_read(4'h8, 8'h00, 11);
    bus_write(4'h0, 8'h01);
    bus_read(4'h8, 8'h00, 11);
    bus_write(4'h1, 8'h01);
    bus_read(4'h8, 8'h00, 11);

    report();
  end
endmodule